// File: doc/BRIEF.md
# Prioritized Interrupt Controller

The block gathers fifteen interrupt sources into one pending register and hands the processor a single request. Ten sources are internal event pulses, such as the watchdog timeout, the two timers, and the error and communication events. The other five come from external pins. Each source owns one pending bit, and bit index `i` stands for trap type `0x11 + i`. Bit 14 (trap `0x1F`) is the watchdog timeout and has the highest priority. Bit 0 (trap `0x11`) is the lowest.

A per-source enable mask gates the pending bits. The watchdog bit bypasses the mask and always reaches the output. The block then presents the highest unmasked pending source as a level request with a 4-bit identifier, which is the low nibble of its trap type. When the processor acknowledges that identifier, the block clears the pending bit by itself. If the served source was an external pin, the block also pulses an acknowledge output.

A small register port gives access to six things:
- the shape of the external inputs (polarity, and edge or level sensing);
- the pending bits, read only;
- the enable mask;
- a write-one clear;
- a write-one force;
- reads of the clear and force addresses, which return zero.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the pending, mask and shape registers read 0, and `irq_req`, `irq_id` and `ext_ack_o` are all 0.
- R2: Internal event `int_evt_i[k]` sets pending bit `P[k]` at the clock edge where it is high, with `P = {14,12,11,8,7,6,5,4,3,0}` for k = 9..0. The bit then stays set until it is cleared.
- R3: A pending bit raises `irq_req` only if its mask bit is 1 (mask register, address 2). Pending bit 14 raises `irq_req` regardless of the mask.
- R4: `irq_id` equals one plus the highest index among the pending bits that pass the mask. It is 0 when none pass.
- R5: `ack_i` with `ack_id_i = n` (n = 1..15) clears pending bit n-1 at that clock edge.
- R6: An acknowledge whose identifier belongs to an external source (`ext_i[4:0]` maps to pending bits `{13,10,9,2,1}`) drives `ext_ack_o` high for the following cycle only. Acknowledges of internal sources leave it low.
- R7: A write to address 3 (clear) clears exactly the pending bits written as 1. A write to address 4 (force) sets exactly the pending bits written as 1. Bits written as 0 are unchanged. Writes to address 1 (pending) have no effect.
- R8: When a pending bit is set and cleared at the same edge, it ends up set.
- R9: External pins pass through a two-stage synchronizer. The pending bit is visible three clock edges after the pin changes. Shape bit e (address 0) set to 1 makes `ext_i[e]` active low. An inactive pin sets nothing.
- R10: Shape bit 5+e set to 1 selects edge mode. In edge mode, only the inactive-to-active transition sets the pending bit, so an input held active does not set it again after an acknowledge. In level mode (shape bit 5+e = 0), the bit is set again on every cycle the input stays active.
- R11: Reads at address 0, 1 and 2 return the shape, pending and mask registers. Reads at addresses 3 and 4 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_evt_i | input | 10 | Internal event pulses |
| ext_i | input | 5 | External interrupt pins, asynchronous |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| ack_id_i | input | 4 | Identifier being acknowledged |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 15 | Register write data |
| reg_rdata | output | 15 | Register read data, combinational |
| irq_req | output | 1 | Interrupt request level |
| irq_id | output | 4 | Identifier of the winning source |
| ext_ack_o | output | 1 | One-cycle pulse on acknowledge of an external source |

## Verification
Internal events, register writes and acknowledges take effect at the next edge. Because `irq_req`, `irq_id` and `reg_rdata` are combinational from the registers, their new values are checked one cycle after the stimulus. External pins need three edges before their pending bit appears. The bench therefore also checks that nothing is pending after two edges, which pins the synchronizer depth. `ext_ack_o` is checked high exactly one cycle after the acknowledge and low one cycle later. The bench drives all inputs just after the falling edge and samples outputs before the next falling edge, so each expected cycle is counted in whole edges.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NSRC = 15,
  parameter int NEXT = 5,
  parameter int NINT = 10,
  parameter int AW   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NINT-1:0]   int_evt_i,
  input  logic [NEXT-1:0]   ext_i,
  input  logic              ack_i,
  input  logic [3:0]        ack_id_i,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [NSRC-1:0]   reg_wdata,
  output logic [NSRC-1:0]   reg_rdata,
  output logic              irq_req,
  output logic [3:0]        irq_id,
  output logic              ext_ack_o
);
  localparam int WDOG = NSRC - 1;
  localparam int SHW  = 2 * NEXT;
  localparam int INT_POS [NINT] = '{0, 3, 4, 5, 6, 7, 8, 11, 12, 14};
  localparam int EXT_POS [NEXT] = '{1, 2, 9, 10, 13};
  localparam logic [AW-1:0] A_SHAPE = AW'(0), A_PEND = AW'(1), A_MASK = AW'(2),
                            A_CLR = AW'(3), A_FORCE = AW'(4);

  logic [NEXT-1:0] s1_q, s2_q, prev_q, hit;
  logic [SHW-1:0]  shape_q;
  logic [NSRC-1:0] pend_q, mask_q, set_vec, clr_vec, live;
  logic            ext_ack_q, ack_ext;

  wire wr_clr   = reg_wr && reg_addr == A_CLR;
  wire wr_force = reg_wr && reg_addr == A_FORCE;
  wire [NEXT-1:0] cond = s2_q ^ shape_q[NEXT-1:0];

  assign hit = cond & (~shape_q[SHW-1:NEXT] | ~prev_q);

  always_comb begin
    set_vec = wr_force ? reg_wdata : '0;
    clr_vec = wr_clr ? reg_wdata : '0;
    ack_ext = 1'b0;
    for (int k = 0; k < NINT; k++) set_vec[INT_POS[k]] = set_vec[INT_POS[k]] | int_evt_i[k];
    for (int e = 0; e < NEXT; e++) begin
      set_vec[EXT_POS[e]] = set_vec[EXT_POS[e]] | hit[e];
      if (ack_i && ack_id_i == 4'(EXT_POS[e] + 1)) ack_ext = 1'b1;
    end
    for (int i = 0; i < NSRC; i++)
      if (ack_i && ack_id_i == 4'(i + 1)) clr_vec[i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_q <= '0; s2_q <= '0; prev_q <= '0;
      shape_q <= '0; mask_q <= '0; pend_q <= '0; ext_ack_q <= 1'b0;
    end else begin
      s1_q      <= ext_i;
      s2_q      <= s1_q;
      prev_q    <= cond;
      pend_q    <= (pend_q & ~clr_vec) | set_vec;
      ext_ack_q <= ack_ext;
      if (reg_wr && reg_addr == A_SHAPE) shape_q <= reg_wdata[SHW-1:0];
      if (reg_wr && reg_addr == A_MASK)  mask_q  <= reg_wdata;
    end

  assign live = pend_q & (mask_q | (NSRC'(1) << WDOG));
  assign irq_req = |live;
  assign ext_ack_o = ext_ack_q;

  always_comb begin
    irq_id = '0;
    for (int i = 0; i < NSRC; i++) if (live[i]) irq_id = 4'(i + 1);
  end

  always_comb
    case (reg_addr)
      A_SHAPE: reg_rdata = NSRC'(shape_q);
      A_PEND:  reg_rdata = pend_q;
      A_MASK:  reg_rdata = mask_q;
      default: reg_rdata = '0;
    endcase

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> (!irq_req && irq_id == 4'd0));
  a_r3_wdog_passes: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q[WDOG] |-> (irq_req && irq_id == 4'hF));
  a_r4_id_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> pend_q[irq_id - 4'd1]);
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && ack_id_i == 4'hF && !set_vec[WDOG]) |=> !pend_q[WDOG]);
  a_r6_ext_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ack_o |-> $past(ack_i));
  a_r7_force_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wr_force |=> ((pend_q & $past(reg_wdata)) == $past(reg_wdata)));
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [9:0] int_evt_i = '0;
  logic [4:0] ext_i = '0;
  logic ack_i = 1'b0, reg_wr = 1'b0;
  logic [3:0] ack_id_i = '0;
  logic [2:0] reg_addr = '0;
  logic [14:0] reg_wdata = '0, reg_rdata;
  logic irq_req, ext_ack_o;
  logic [3:0] irq_id;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  irq_prio_ctrl dut_i (.clk(clk), .rst_n(rst_n), .int_evt_i(int_evt_i), .ext_i(ext_i),
    .ack_i(ack_i), .ack_id_i(ack_id_i), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_id(irq_id),
    .ext_ack_o(ext_ack_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [14:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [14:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic ack(input logic [3:0] id);
    ack_i = 1'b1; ack_id_i = id;
    step();
    ack_i = 1'b0; ack_id_i = '0;
  endtask

  task automatic t_reset;
    logic [14:0] v;
    chk("R1 irq_req", 32'(irq_req), 0);
    chk("R1 irq_id", 32'(irq_id), 0);
    chk("R1 ext_ack", 32'(ext_ack_o), 0);
    rd(3'd1, v); chk("R1 pending", 32'(v), 0);
    rd(3'd2, v); chk("R1 mask", 32'(v), 0);
    rd(3'd0, v); chk("R1 shape", 32'(v), 0);
  endtask

  task automatic t_internal;
    logic [14:0] v;
    int_evt_i[0] = 1'b1; step(); int_evt_i[0] = 1'b0;
    rd(3'd1, v); chk("R2 internal event latched", 32'(v), 32'h0001);
    chk("R3 masked source silent", 32'(irq_req), 0);
    wr(3'd2, 15'h0001);
    chk("R3 enabled source requests", 32'(irq_req), 1);
    chk("R4 id of bit 0", 32'(irq_id), 1);
    rd(3'd2, v); chk("R11 mask readback", 32'(v), 32'h0001);
    int_evt_i[9] = 1'b1; step(); int_evt_i[9] = 1'b0;
    chk("R3 watchdog ignores mask", 32'(irq_id), 32'hF);
    ack(4'hF);
    rd(3'd1, v); chk("R5 ack clears watchdog", 32'(v), 32'h0001);
    chk("R6 internal ack no pulse", 32'(ext_ack_o), 0);
    chk("R4 id falls back", 32'(irq_id), 1);
  endtask

  task automatic t_regs;
    logic [14:0] v;
    wr(3'd2, 15'h7FFF);
    wr(3'd4, 15'h1800);
    chk("R4 highest wins", 32'(irq_id), 32'hD);
    wr(3'd3, 15'h1000);
    rd(3'd1, v); chk("R7 clear selected bit", 32'(v), 32'h0801);
    chk("R4 next highest", 32'(irq_id), 32'hC);
    rd(3'd4, v); chk("R11 force reads zero", 32'(v), 0);
    wr(3'd1, 15'h7FFF);
    rd(3'd1, v); chk("R7 pending write ignored", 32'(v), 32'h0801);
    wr(3'd3, 15'h0800);
    rd(3'd1, v); chk("R7 zero bits untouched", 32'(v), 32'h0001);
    int_evt_i[0] = 1'b1; wr(3'd3, 15'h0001); int_evt_i[0] = 1'b0;
    rd(3'd1, v); chk("R8 set beats clear", 32'(v), 32'h0001);
    wr(3'd3, 15'h7FFF);
    chk("R7 all cleared", 32'(irq_req), 0);
  endtask

  task automatic t_ext_level;
    logic [14:0] v;
    ext_i[0] = 1'b1; step(2);
    rd(3'd1, v); chk("R9 not yet after two edges", 32'(v), 0);
    step();
    rd(3'd1, v); chk("R9 level source after three edges", 32'(v), 32'h0002);
    chk("R4 id external 0", 32'(irq_id), 2);
    ack(4'd2);
    chk("R6 ext ack pulse", 32'(ext_ack_o), 1);
    rd(3'd1, v); chk("R10 level re-sets while active", 32'(v), 32'h0002);
    step();
    chk("R6 pulse one cycle", 32'(ext_ack_o), 0);
    ext_i[0] = 1'b0; step(4);
    ack(4'd2); step();
    rd(3'd1, v); chk("R5 cleared after release", 32'(v), 0);
  endtask

  task automatic t_ext_edge;
    logic [14:0] v;
    wr(3'd0, 15'h0200);
    rd(3'd0, v); chk("R11 shape readback", 32'(v), 32'h0200);
    ext_i[4] = 1'b1; step(3);
    rd(3'd1, v); chk("R10 edge latched", 32'(v), 32'h2000);
    chk("R4 id external 4", 32'(irq_id), 32'hE);
    ack(4'hE);
    chk("R6 ext 4 ack pulse", 32'(ext_ack_o), 1);
    step(2);
    rd(3'd1, v); chk("R10 held input no retrigger", 32'(v), 0);
    ext_i[4] = 1'b0; step(3);
  endtask

  task automatic t_ext_low;
    logic [14:0] v;
    ext_i[3] = 1'b1; step(3);
    wr(3'd0, 15'h0308);
    step(2);
    wr(3'd3, 15'h7FFF);
    step(2);
    rd(3'd1, v); chk("R9 inactive-high pin sets nothing", 32'(v), 0);
    ext_i[3] = 1'b0; step(3);
    rd(3'd1, v); chk("R9 active-low edge", 32'(v), 32'h0400);
    chk("R4 id external 3", 32'(irq_id), 32'hB);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    step(2);
    t_reset();
    rst_n = 1'b1;
    step();
    t_internal();
    t_regs();
    t_ext_level();
    t_ext_edge();
    t_ext_low();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule